// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Controller

This block watches a bank of already-synchronized pin levels and raises a per-pin interrupt status flag when a qualified level change matches the pin's edge configuration. Each pin has its own settings: input or output direction, interrupt enable, rising select, falling select and glitch-filter enable. All pin status flags are ORed into one enable for an active-low open-drain interrupt driver. When a pad driver sees that enable high, it pulls the shared interrupt line low.

The filter turns a raw level into a qualified level. With the filter off, the qualified level follows the pin one clock later. With it on, a new level is accepted only after it has been sampled for `FILT_CLKS` clocks in a row. The parameter is meant to land between the two pulse-width limits the system needs, which are about 225 ns rejected and 1075 ns accepted. For example, 16 clocks at 25 MHz gives 640 ns.

Status is cleared by per-bank read strobes that come from the state-register read path. In the default mode, where both selects are 0, a flag also clears by itself when the pin goes back to the level captured at the last read.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, `irq_status` is all zeros and `irq_drive_low` is 0, and every qualified level is 0.
- R2: A pin whose `cfg_is_in` bit is 0 (output) or whose `cfg_irq_en` bit is 0 never has its status bit set.
- R3: Mode {rise,fall}=00: any qualified change away from the reference level sets status. The reference level is the qualified level captured at the last read of the pin's bank; while the flag is clear, the reference follows the qualified level. Status clears on a bank read, or when the qualified level returns to the reference.
- R4: Mode {rise,fall}=10 sets status only on qualified 0-to-1 changes. Mode 01 sets status only on 1-to-0 changes. In both modes only a bank read clears status.
- R5: Mode {rise,fall}=11 sets status on either qualified change, and only a bank read clears status.
- R6: With the filter bit at 0, a pin change present before a clock edge shows in `irq_status` right after that edge and not before it.
- R7: With the filter bit at 1, a new level counts only after `FILT_CLKS` consecutive samples. Status shows right after the `FILT_CLKS`-th sampling edge. A pulse of `FILT_CLKS`-1 samples has no effect.
- R8: `irq_drive_low` is 1 exactly when any `irq_status` bit is 1, in the same cycle.
- R9: `rd_state[b]` clears status for pins b*`BANK_W` through b*`BANK_W`+`BANK_W`-1 only. With the defaults, bit 0 covers pins 0–7 and bit 1 covers pins 8–15.
- R10: A qualified change that matches the mode in the same cycle as a clearing read leaves status set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| cfg_is_in | input | NPINS | 1 = pin is an input |
| cfg_irq_en | input | NPINS | Per-pin interrupt enable |
| cfg_rise_sel | input | NPINS | Rising select bit of the edge mode |
| cfg_fall_sel | input | NPINS | Falling select bit of the edge mode |
| cfg_filt_en | input | NPINS | Per-pin glitch-filter enable |
| rd_state | input | NPINS/BANK_W | One-cycle strobe per bank: state register of that bank read |
| irq_status | output | NPINS | Per-pin interrupt status |
| irq_drive_low | output | 1 | Enable for the open-drain active-low interrupt driver |

## Verification
With the filter off, a pin change driven before edge k shows in status right after edge k, and the bench first samples before that edge to confirm status is still clear. With the filter on, status is due right after edge k+`FILT_CLKS`-1; the bench samples one edge earlier and expects nothing, then samples at that edge and expects the flag. A read strobe takes effect at the edge that samples it, and the interrupt enable follows status with no extra cycle. All stimulus is driven on the falling clock edge and sampled on the next falling edge after the counted rising edges, so each expected value is tied to a known edge count.

// File: rtl/pei_pkg.sv
package pei_pkg;

   // Edge mode, encoded as {rise_sel, fall_sel}
   typedef enum logic [1:0] {
      EM_ANY_AUTO = 2'b00,
      EM_FALL     = 2'b01,
      EM_RISE     = 2'b10,
      EM_ANY_HOLD = 2'b11
   } edge_mode_e;

   function automatic edge_mode_e mode_of(input logic rise_sel, input logic fall_sel);
      return edge_mode_e'({rise_sel, fall_sel});
   endfunction

endpackage

// File: rtl/pei_filter.sv
module pei_filter #(
   parameter int unsigned FILT_CLKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic filt_en,
   output logic q,
   output logic q_nxt
);

   generate
      if (FILT_CLKS <= 1) begin : g_bypass
         // A one-sample filter is the same as no filter
         always_comb q_nxt = pin;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= q_nxt;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(FILT_CLKS);
         localparam logic [CW-1:0] LAST = CW'(FILT_CLKS - 1);
         logic [CW-1:0] cnt, cnt_nxt;

         always_comb begin
            q_nxt   = q;
            cnt_nxt = cnt;
            if (!filt_en) begin
               q_nxt   = pin;
               cnt_nxt = '0;
            end else if (pin == q) begin
               cnt_nxt = '0;
            end else if (cnt == LAST) begin
               q_nxt   = pin;
               cnt_nxt = '0;
            end else begin
               cnt_nxt = cnt + 1'b1;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q   <= 1'b0;
               cnt <= '0;
            end else begin
               q   <= q_nxt;
               cnt <= cnt_nxt;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pei_status_cell.sv
module pei_status_cell
   import pei_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       q_cur,
   input  logic       q_nxt,
   input  logic       en,
   input  edge_mode_e mode,
   input  logic       rd,
   output logic       status
);

   logic ref_q, ref_base, st_nxt, rise_ev, fall_ev, sel_ev;

   always_comb begin
      // The reference is re-captured on a read and follows the level while no flag is pending
      ref_base = (rd || !status) ? q_cur : ref_q;
      rise_ev  = q_nxt & ~q_cur;
      fall_ev  = ~q_nxt & q_cur;
      unique case (mode)
         EM_RISE:     sel_ev = rise_ev;
         EM_FALL:     sel_ev = fall_ev;
         default:     sel_ev = rise_ev | fall_ev;
      endcase
      if (mode == EM_ANY_AUTO) st_nxt = en & (q_nxt ^ ref_base);
      else                     st_nxt = en & (sel_ev | (status & ~rd));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
         ref_q  <= 1'b0;
      end else begin
         status <= st_nxt;
         ref_q  <= ref_base;
      end
   end

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
   import pei_pkg::*;
#(
   parameter int unsigned NPINS     = 16,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned FILT_CLKS = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPINS-1:0]              pin_lvl,
   input  logic [NPINS-1:0]              cfg_is_in,
   input  logic [NPINS-1:0]              cfg_irq_en,
   input  logic [NPINS-1:0]              cfg_rise_sel,
   input  logic [NPINS-1:0]              cfg_fall_sel,
   input  logic [NPINS-1:0]              cfg_filt_en,
   input  logic [NPINS/BANK_W-1:0]       rd_state,
   output logic [NPINS-1:0]              irq_status,
   output logic                          irq_drive_low
);

   localparam int unsigned NBANKS = NPINS / BANK_W;

   generate
      if (NPINS == 0 || BANK_W == 0 || (NPINS % BANK_W) != 0) begin : g_bad_bank
         $error("pin_edge_irq: NPINS must be a nonzero multiple of BANK_W");
      end
      if (FILT_CLKS == 0) begin : g_bad_filt
         $error("pin_edge_irq: FILT_CLKS must be at least 1");
      end
   endgenerate

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam int unsigned BANK = p / BANK_W;
      logic q_cur, q_nxt;

      pei_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (pin_lvl[p]),
         .filt_en (cfg_filt_en[p]),
         .q       (q_cur),
         .q_nxt   (q_nxt)
      );

      pei_status_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .q_cur  (q_cur),
         .q_nxt  (q_nxt),
         .en     (cfg_is_in[p] & cfg_irq_en[p]),
         .mode   (mode_of(cfg_rise_sel[p], cfg_fall_sel[p])),
         .rd     (rd_state[BANK]),
         .status (irq_status[p])
      );
   end

   assign irq_drive_low = |irq_status;

   if (NBANKS == 0) begin : g_never
      $error("pin_edge_irq: no banks");
   end

endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
   parameter int unsigned NPINS     = 16,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned FILT_CLKS = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPINS-1:0]        pin_lvl,
   input logic [NPINS-1:0]        cfg_is_in,
   input logic [NPINS-1:0]        cfg_irq_en,
   input logic [NPINS-1:0]        cfg_rise_sel,
   input logic [NPINS-1:0]        cfg_fall_sel,
   input logic [NPINS-1:0]        cfg_filt_en,
   input logic [NPINS/BANK_W-1:0] rd_state,
   input logic [NPINS-1:0]        irq_status,
   input logic                    irq_drive_low
);

   localparam int unsigned RW = $clog2(FILT_CLKS + 1);
   localparam logic [RW-1:0] RMAX = RW'(FILT_CLKS);
   localparam logic [RW-1:0] RNEED = RW'(FILT_CLKS - 1);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_chk
      localparam int unsigned BANK = p / BANK_W;
      logic          prev_pin;
      logic [RW-1:0] run;

      // Count how many samples in a row the pin has held its level
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_pin <= 1'b0;
            run      <= '0;
         end else begin
            prev_pin <= pin_lvl[p];
            if (pin_lvl[p] != prev_pin) run <= '0;
            else if (run != RMAX)       run <= run + 1'b1;
         end
      end

      a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && !$past(cfg_is_in[p] & cfg_irq_en[p]) |-> !irq_status[p]);

      a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $rose(irq_status[p]) && $past(cfg_rise_sel[p] & ~cfg_fall_sel[p])
         |-> $past(pin_lvl[p]));

      a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $rose(irq_status[p]) && $past(~cfg_rise_sel[p] & cfg_fall_sel[p])
         |-> !$past(pin_lvl[p]));

      a_r5_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
         irq_status[p] && !rd_state[BANK] && (cfg_rise_sel[p] | cfg_fall_sel[p])
         && cfg_is_in[p] && cfg_irq_en[p]
         |=> irq_status[p] || !(cfg_is_in[p] & cfg_irq_en[p])
             || !(cfg_rise_sel[p] | cfg_fall_sel[p]));

      a_r7_filter_width: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $rose(irq_status[p]) && $past(cfg_filt_en[p]) |-> run >= RNEED);
   end

endmodule

bind pin_edge_irq pin_edge_irq_chk #(
   .NPINS(NPINS), .BANK_W(BANK_W), .FILT_CLKS(FILT_CLKS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pin_lvl      (pin_lvl),
   .cfg_is_in    (cfg_is_in),
   .cfg_irq_en   (cfg_irq_en),
   .cfg_rise_sel (cfg_rise_sel),
   .cfg_fall_sel (cfg_fall_sel),
   .cfg_filt_en  (cfg_filt_en),
   .rd_state     (rd_state),
   .irq_status   (irq_status),
   .irq_drive_low(irq_drive_low)
);

// File: tb/test_pin_edge_irq.sv
`timescale 1ns/1ps
module test_pin_edge_irq;

   localparam int NP = 16;
   localparam int BW = 8;
   localparam int FC = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] pins, is_in, ien, rsel, fsel, fen;
   logic [1:0]    rd;
   logic [NP-1:0] status;
   logic          irq_low;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pin_edge_irq #(.NPINS(NP), .BANK_W(BW), .FILT_CLKS(FC)) i_pin_edge_irq (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .cfg_is_in(is_in),
      .cfg_irq_en(ien), .cfg_rise_sel(rsel), .cfg_fall_sel(fsel),
      .cfg_filt_en(fen), .rd_state(rd), .irq_status(status),
      .irq_drive_low(irq_low)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_irq(input string req);
      chk(req, {15'd0, irq_low}, {15'd0, (status != '0)});
   endtask

   task automatic read_all();
      rd = 2'b11;
      tick();
      rd = 2'b00;
   endtask

   task automatic set_mode(input int m);
      rsel = m[1] ? '1 : '0;
      fsel = m[0] ? '1 : '0;
   endtask

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] pats [4];
      logic [NP-1:0] exp;
      pats[0] = 16'hA5C3; pats[1] = 16'h0001; pats[2] = 16'h8000; pats[3] = 16'hFFFF;

      rst_n = 1'b0; pins = '0; is_in = '0; ien = '0; rsel = '0; fsel = '0; fen = '0; rd = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 status", status, '0);
      chk("R1 irq", {15'd0, irq_low}, '0);

      // R2 disabled or output pins stay quiet
      is_in = '1; ien = '0; pins = '1; tick();
      chk("R2 enable=0", status, '0);
      is_in = '0; ien = '1; pins = '0; tick();
      chk("R2 output fall", status, '0);
      pins = '1; tick();
      chk("R2 output rise", status, '0);
      pins = '0; tick();

      // Sweep modes and patterns, filter off
      is_in = '1; ien = '1; fen = '0;
      for (int pi = 0; pi < 4; pi++) begin
         for (int m = 0; m < 4; m++) begin
            set_mode(m);
            pins = '0;
            read_all();
            tick();
            chk("R3/R4/R5 start clear", status, '0);
            pins = pats[pi];
            tick();
            exp = (m == 1) ? '0 : pats[pi];
            chk(m == 0 ? "R3 rise" : (m == 3 ? "R5 rise" : "R4 rise"), status, exp);
            chk_irq("R8 after rise");
            pins = '0;
            tick();
            exp = (m == 0) ? '0 : pats[pi];
            chk(m == 0 ? "R3 auto clear" : (m == 3 ? "R5 fall" : "R4 fall/hold"), status, exp);
            chk_irq("R8 after fall");
            read_all();
            chk("R3/R4/R5 read clears", status, '0);
            chk_irq("R8 after read");
         end
      end

      // R6 latency with filter off, mode both-hold
      set_mode(3);
      pins = 16'h0F0F;
      #1;
      chk("R6 before edge", status, '0);
      tick();
      chk("R6 after edge", status, 16'h0F0F);
      pins = '0; tick(); read_all();

      // R9 bank-wise clear
      pins = '1; tick();
      chk("R9 all set", status, '1);
      rd = 2'b01; tick(); rd = 2'b00;
      chk("R9 low bank cleared", status, 16'hFF00);
      rd = 2'b10; tick(); rd = 2'b00;
      chk("R9 high bank cleared", status, '0);

      // R10 edge coinciding with read
      pins = '0; rd = 2'b11; tick(); rd = 2'b00;
      chk("R10 edge during read", status, '1);
      read_all();
      chk("R10 then cleared", status, '0);

      // R3 reference captured at read (pins currently 0, status clear)
      set_mode(0);
      pins = '1; tick();
      chk("R3 set from 0", status, '1);
      read_all();
      chk("R3 read clears", status, '0);
      pins = '0; tick();
      chk("R3 change from captured 1", status, '1);
      pins = '1; tick();
      chk("R3 return to captured level", status, '0);
      pins = '0; tick();
      chk("R3 leave again", status, '1);
      read_all();
      chk("R3 clear at 0", status, '0);

      // R7 filter: pins 0, qualified 0
      set_mode(3); fen = '1;
      pins = '1;
      repeat (FC - 1) tick();
      pins = '0;
      repeat (FC + 1) tick();
      chk("R7 short pulse rejected", status, '0);
      pins = '1;
      repeat (FC - 1) tick();
      chk("R7 one sample short", status, '0);
      tick();
      chk("R7 qualified at FILT_CLKS", status, '1);
      read_all();
      chk("R7 cleared", status, '0);
      // mixed filter enables: high byte unfiltered sees a 2-sample pulse
      fen = 16'h00FF;
      pins = '0; repeat (2) tick();
      pins = '1; repeat (FC + 1) tick();
      chk("R7 per-pin filter", status, 16'hFF00);
      read_all();
      chk("R7 mixed cleared", status, '0);

      done = 1;
      report();
      $finish;
   end

endmodule